// File: doc/BRIEF.md
# MDIO Management Command Controller

This block carries out one MII management transaction at a time towards an external PHY on the two-wire MDC/MDIO bus. Software programs a control register with the MDC clock divisor and the preamble option, loads the data register when a write is wanted, and then writes the command register with the operation, the PHY address and the register number. That command write starts the serial frame. Software polls the busy flag in the status register and, once it drops, reads the returned word from the data register.

MDC is derived from the system clock by a programmable integer divisor. The 32-bit preamble of ones can be left out for PHYs that accept suppressed preambles. The MDIO pin is split into a data output, an output enable and a data input, so the tri-state buffer sits outside the block.

Registers are chosen by a 2-bit select: 0 is control, 1 is command, 2 is data and 3 is status. A write takes effect on the clock edge where `reg_we` is high. Read data is a combinational function of `reg_sel`.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all four registers read zero, MDC is low and the MDIO output enable is low.
- R2: Command register bit 15 requests a read, bit 14 requests a write, bits 9:5 hold the PHY address and bits 4:0 hold the register number. A command with both or neither operation bit set is ignored and starts nothing.
- R3: Each frame is sent MSB first as follows: preamble of 32 ones, start bits 0 then 1, opcode (1,0 for read or 0,1 for write), 5 PHY address bits, 5 register bits, a turnaround, then 16 data bits. In a write, every bit is driven, the turnaround is 1 then 0, and the data is the value the data register held when the command was accepted.
- R4: In a read, MDIO is driven only up to and including the register number. From the turnaround onward the output enable is low. The 16 data bits are sampled on MDC rising edges, and the word appears in the data register on the same clock edge that clears busy.
- R5: Control bits 15:9 hold the divisor minus one, giving a divisor N = field + 1. Field values 0 and 1 both give N = 2. Each bit lasts N clocks: MDC is low for N - floor(N/2) clocks and then high for floor(N/2) clocks. MDC stays low when idle.
- R6: The MDIO output and its enable change only on the clock edge where MDC falls, or on the edge that accepts a command. They never change while MDC is high.
- R7: Status bit 0 (busy) rises on the edge that accepts a command. It falls exactly (frame bits × N) clocks later, on an MDC falling edge.
- R8: Control bit 8 suppresses the preamble, which shortens the frame to 32 bits.
- R9: Writes to the command or data register while busy, or while a soft reset is pending, are ignored.
- R10: The divisor and the preamble option are captured when a command is accepted. Changing the control register during a transaction does not alter that transaction.
- R11: Control bit 0 is a soft reset. It reads 1 for exactly one clock after it is written and then clears itself. On that clearing edge it aborts any transaction and clears the command and data registers. The other control fields keep the values written along with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 command, 2 data, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
Busy and the first frame bit appear one clock after the command write edge. Each later bit starts N clocks after the previous one, and MDC rises N - floor(N/2) clocks into the bit. Read data and the busy drop land on the same edge, (frame bits × N) clocks after acceptance. The soft-reset bit is visible for one clock and its effects take hold on the following edge. A behavioural model in the bench advances on every rising edge from the same register writes. On every falling edge, it is compared against MDC, the MDIO output and enable, and the selected register. On top of this, the MDC high phases in each transaction are counted against the frame length and divisor.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W      = 32;
  localparam int SEL_W      = 2;
  localparam int DIV_W      = 7;
  localparam int CNT_W      = DIV_W + 1;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;

  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd2;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd3;

  localparam int CMD_RD_BIT = 15;
  localparam int CMD_WR_BIT = 14;
  localparam int PHY_LSB    = 5;
  localparam int DIV_LSB    = 9;
  localparam int PSUP_BIT   = 8;
  localparam int SRST_BIT   = 0;

  // effective divisor: field + 1, never below two
  function automatic logic [CNT_W-1:0] div_eff(input logic [DIV_W-1:0] f);
    logic [CNT_W-1:0] n;
    n = CNT_W'(f) + CNT_W'(1);
    return (n < CNT_W'(2)) ? CNT_W'(2) : n;
  endfunction

  // clocks spent with MDC low in one bit period
  function automatic logic [CNT_W-1:0] low_len(input logic [CNT_W-1:0] n);
    return n - (n >> 1);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic rd,
      input logic [ADDR_W-1:0] phy, input logic [ADDR_W-1:0] rg,
      input logic [DATA_W-1:0] wd);
    return {{PRE_BITS{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b1}} : wd)};
  endfunction

  function automatic logic bit_driven(input logic rd, input logic [IDX_W-1:0] idx);
    return !rd || (idx < IDX_W'(TA_POS));
  endfunction

  function automatic logic frame_bit(input logic [FRAME_BITS-1:0] fr,
      input logic [IDX_W-1:0] idx);
    return fr[IDX_W'(FRAME_BITS - 1) - idx];
  endfunction
endpackage

// File: rtl/mdio_mdc_phase.sv
module mdio_mdc_phase
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] n_div,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q == n_div - CNT_W'(1));
  assign rise_evt = run && (cnt_q == low_len(n_div) - CNT_W'(1));
  assign fall_evt = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || at_end)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < n_div));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] rg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              psup,
  input  logic [DIV_W-1:0]  div_field,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              is_rd,
  output logic [DATA_W-1:0] rx_word
);
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]      bidx_q, first_idx, next_idx;
  logic [CNT_W-1:0]      n_q;
  logic                  busy_q, mdc_q, o_q, oe_q, rd_q;
  logic [DATA_W-1:0]     rx_q;
  logic                  rise_evt, fall_evt, last_bit;

  assign frame_d   = build_frame(start_rd, phy, rg, wdata);
  assign first_idx = psup ? IDX_W'(PRE_BITS) : '0;
  assign next_idx  = bidx_q + IDX_W'(1);
  assign last_bit  = (bidx_q == IDX_W'(FRAME_BITS - 1));
  assign done      = busy_q && fall_evt && last_bit;

  mdio_mdc_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .n_div    (n_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; mdc_q <= 1'b0; o_q <= 1'b1; oe_q <= 1'b0; rd_q <= 1'b0;
      bidx_q <= '0; frame_q <= '0; n_q <= CNT_W'(2); rx_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0; mdc_q <= 1'b0; o_q <= 1'b1; oe_q <= 1'b0;
    end else if (start) begin
      busy_q  <= 1'b1;
      mdc_q   <= 1'b0;
      n_q     <= div_eff(div_field);
      rd_q    <= start_rd;
      frame_q <= frame_d;
      bidx_q  <= first_idx;
      o_q     <= frame_bit(frame_d, first_idx);
      oe_q    <= bit_driven(start_rd, first_idx);
    end else if (busy_q) begin
      if (rise_evt) begin
        mdc_q <= 1'b1;
        if (rd_q && bidx_q >= IDX_W'(DATA_POS)) rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        mdc_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0; oe_q <= 1'b0; o_q <= 1'b1;
        end else begin
          bidx_q <= next_idx;
          o_q    <= frame_bit(frame_q, next_idx);
          oe_q   <= bit_driven(rd_q, next_idx);
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign is_rd   = rd_q;
  assign rx_word = rx_q;

  assert_mdc_low_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc_q);
  assert_pin_quiet_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_q |-> ($stable(o_q) && $stable(oe_q)));
  assert_read_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && bidx_q >= IDX_W'(TA_POS)) |-> !oe_q);
  assert_end_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mdc_q);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              psup_q, srst_q;
  logic [DATA_W-1:0] cmd_q, data_q;
  logic              wr_ctrl, wr_cmd, wr_data, op_ok, start;
  logic              seq_busy, seq_done, seq_rd;
  logic [DATA_W-1:0] rx_word;
  logic              unused_bits;

  assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign wr_cmd  = reg_we && (reg_sel == SEL_CMD);
  assign wr_data = reg_we && (reg_sel == SEL_DATA);
  assign op_ok   = reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT];
  assign start   = wr_cmd && op_ok && !seq_busy && !srst_q;
  assign unused_bits = ^{reg_wdata[REG_W-1:DATA_W], reg_wdata[13:10], reg_wdata[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0; psup_q <= 1'b0; srst_q <= 1'b0;
    end else if (wr_ctrl) begin
      div_q  <= reg_wdata[DIV_LSB +: DIV_W];
      psup_q <= reg_wdata[PSUP_BIT];
      srst_q <= reg_wdata[SRST_BIT];
    end else begin
      srst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst_q) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (start) cmd_q <= reg_wdata[DATA_W-1:0];
      if (seq_done && seq_rd)       data_q <= rx_word;
      else if (wr_data && !seq_busy) data_q <= reg_wdata[DATA_W-1:0];
    end
  end

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (srst_q),
    .start_rd  (reg_wdata[CMD_RD_BIT]),
    .phy       (reg_wdata[PHY_LSB +: ADDR_W]),
    .rg        (reg_wdata[ADDR_W-1:0]),
    .wdata     (data_q),
    .psup      (psup_q),
    .div_field (div_q),
    .mdio_i    (mdio_i),
    .busy      (seq_busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (seq_done),
    .is_rd     (seq_rd),
    .rx_word   (rx_word)
  );

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {16'b0, div_q, psup_q, 7'b0, srst_q};
      SEL_CMD:  reg_rdata = {16'b0, cmd_q};
      SEL_DATA: reg_rdata = {16'b0, data_q};
      default:  reg_rdata = {31'b0, seq_busy};
    endcase
  end

  assert_cmd_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && seq_busy && !srst_q) |=> $stable(cmd_q));
  assert_data_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && seq_busy && !srst_q && !seq_done) |=> $stable(data_q));
  assert_srst_self_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !(wr_ctrl && reg_wdata[SRST_BIT])) |=> (!srst_q && !seq_busy && data_q == '0));
  assert_bad_op_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !op_ok && !seq_busy) |=> !seq_busy);
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit drv_active = 1'b0;
  bit cmp_en = 1'b0;
  logic [15:0] phy_word = '0;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // behavioural reference model
  bit m_busy, m_rstp, m_psup, m_rd;
  logic [6:0] m_div;
  logic [15:0] m_cmd, m_data, m_wd, m_phyw;
  logic [4:0] m_phy, m_reg;
  int m_t, m_N = 2, m_L = 1, m_skip, m_nb = 64;
  bit o_busy, o_rstp, o_psup, w_c, w_m, w_d;
  logic [6:0] o_div;
  int idx_n;

  function automatic bit mbit(input int i);
    if (i < 32) return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return m_rd;
    if (i == 35) return !m_rd;
    if (i <= 40) return m_phy[40 - i];
    if (i <= 45) return m_reg[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return m_wd[63 - i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rstp = 0; m_psup = 0; m_rd = 0; m_div = 0;
      m_cmd = 0; m_data = 0; m_t = 0; m_N = 2; m_L = 1; m_skip = 0; m_nb = 64;
      mdio_i <= 1'b1;
    end else begin
      o_busy = m_busy; o_rstp = m_rstp; o_div = m_div; o_psup = m_psup;
      w_c = reg_we && reg_sel == 2'd0;
      w_m = reg_we && reg_sel == 2'd1;
      w_d = reg_we && reg_sel == 2'd2;
      if (o_rstp) begin
        m_busy = 0; m_t = 0; m_data = 0; m_cmd = 0;
      end else begin
        if (o_busy) begin
          m_t++;
          if (m_t == m_nb * m_N) begin
            m_busy = 0; m_t = 0;
            if (m_rd) m_data = m_phyw;
          end
        end
        if (w_m && !o_busy && (reg_wdata[15] != reg_wdata[14])) begin
          m_cmd = reg_wdata[15:0]; m_busy = 1; m_t = 0;
          m_rd = reg_wdata[15]; m_phy = reg_wdata[9:5]; m_reg = reg_wdata[4:0];
          m_wd = m_data; m_phyw = phy_word;
          m_N = (o_div < 2) ? 2 : int'(o_div) + 1;
          m_L = (m_N + 1) / 2;
          m_skip = o_psup ? 32 : 0;
          m_nb = 64 - m_skip;
        end else if (w_d && !o_busy) begin
          m_data = reg_wdata[15:0];
        end
      end
      if (w_c) begin
        m_div = reg_wdata[15:9]; m_psup = reg_wdata[8]; m_rstp = reg_wdata[0];
      end else m_rstp = 0;
      idx_n = m_skip + m_t / m_N;
      mdio_i <= (m_busy && m_rd && idx_n >= 48) ? m_phyw[63 - idx_n] : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int i;
      bit e_mdc, e_oe;
      logic [31:0] e_rd;
      i = m_skip + m_t / m_N;
      e_mdc = m_busy && ((m_t % m_N) >= m_L);
      e_oe = m_busy && (!m_rd || i < 46);
      chk(mdc === e_mdc, "R5 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk(mdio_oe === e_oe, "R4 R3 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe) chk(mdio_o === mbit(i), "R3 R6 mdio_o", {31'b0, mdio_o}, {31'b0, mbit(i)});
      case (reg_sel)
        2'd0: e_rd = {16'b0, m_div, m_psup, 7'b0, m_rstp};
        2'd1: e_rd = {16'b0, m_cmd};
        2'd2: e_rd = {16'b0, m_data};
        default: e_rd = {31'b0, m_busy};
      endcase
      chk(reg_rdata === e_rd, (reg_sel == 2'd3) ? "R7 status" : "R10 R11 R9 register", reg_rdata, e_rd);
    end
  end

  // rotate the read select while the bench is not driving
  always @(posedge clk) begin
    #2;
    if (!drv_active) reg_sel = reg_sel + 2'd1;
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    drv_active = 1; reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0; drv_active = 0;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    drv_active = 1; reg_sel = sel;
    @(negedge clk);
    chk(reg_rdata === exp, tag, reg_rdata, exp);
    drv_active = 0;
  endtask

  // issue a command, count MDC high clocks until the model goes idle
  task automatic txn(input logic [15:0] cmd, input int exp_hi, input string tag);
    int hi = 0;
    wr(2'd1, {16'b0, cmd});
    forever begin
      @(negedge clk);
      if (mdc) hi++;
      if (!m_busy) break;
    end
    chk(hi == exp_hi, tag, hi, exp_hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    drv_active = 1;
    @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 pins after reset", {30'b0, mdc, mdio_oe}, 0);
    drv_active = 0;
    for (int s = 0; s < 4; s++) rd_chk(s[1:0], 32'h0, "R1 register after reset");
    cmp_en = 1;

    // N=2 write with preamble: 64 bits, 1 high clock each
    wr(2'd0, 32'h1 << 9);
    wr(2'd2, 32'hA5C3);
    txn(16'h4000 | (5 << 5) | 3, 64, "R7 R3 write N=2 high clocks");

    // N=2 read with preamble
    phy_word = 16'h3C5A;
    txn(16'h8000 | (5'h11 << 5) | 5'h1F, 64, "R4 read N=2 high clocks");
    rd_chk(2'd2, 32'h3C5A, "R4 read word in data register");

    // N=5 read, preamble suppressed: 32 bits x 2 high clocks
    wr(2'd0, (32'd4 << 9) | (1 << 8));
    phy_word = 16'hBEEF;
    txn(16'h8000 | (5'h02 << 5) | 5'h04, 64, "R8 suppressed preamble N=5");
    rd_chk(2'd2, 32'hBEEF, "R4 read word N=5");

    // divisor field 0 behaves as N=2, suppressed preamble write
    wr(2'd0, 32'h0 | (1 << 8));
    wr(2'd2, 32'h0F0F);
    txn(16'h4000 | (5'h1F << 5) | 5'h00, 32, "R5 field zero gives N=2");

    // malformed commands
    wr(2'd1, 32'hC123);
    wr(2'd1, 32'h0123);
    repeat (3) @(posedge clk);
    rd_chk(2'd3, 32'h0, "R2 malformed command starts nothing");
    rd_chk(2'd1, {16'b0, 16'h4000 | (5'h1F << 5)}, "R2 command register keeps last accepted");

    // N=3 write with disturbances during busy
    wr(2'd0, 32'd2 << 9);
    wr(2'd2, 32'h7E81);
    fork
      begin
        repeat (10) @(posedge clk);
        wr(2'd1, 32'h8000 | (3 << 5) | 1);
        repeat (10) @(posedge clk);
        wr(2'd2, 32'h1234);
        repeat (10) @(posedge clk);
        wr(2'd0, (32'd9 << 9) | (1 << 8));
      end
    join_none
    txn(16'h4000 | (5'h0A << 5) | 5'h15, 64, "R9 R10 N=3 unaffected by writes while busy");
    rd_chk(2'd2, 32'h7E81, "R9 data write while busy ignored");
    rd_chk(2'd0, (32'd9 << 9) | (1 << 8), "R10 control updated for later use");

    // N=40 read with preamble: 64 x 20 high clocks
    wr(2'd0, 32'd39 << 9);
    phy_word = 16'h1357;
    txn(16'h8000 | (5'h01 << 5) | 5'h01, 1280, "R5 N=40 high clocks");
    rd_chk(2'd2, 32'h1357, "R4 read word N=40");

    // soft reset in the middle of a read
    wr(2'd0, 32'd1 << 9);
    phy_word = 16'hFFFF;
    fork
      begin
        repeat (20) @(posedge clk);
        wr(2'd0, (32'd3 << 9) | 1);
      end
    join_none
    wr(2'd1, 32'h8000 | (4 << 5) | 2);
    repeat (40) @(posedge clk);
    rd_chk(2'd3, 32'h0, "R11 soft reset aborts transaction");
    rd_chk(2'd2, 32'h0, "R11 soft reset clears data");
    rd_chk(2'd1, 32'h0, "R11 soft reset clears command");
    rd_chk(2'd0, 32'd3 << 9, "R11 reset bit cleared, divisor kept");

    repeat (5) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule